// File: doc/BRIEF.md
# Level and Single-Edge Trigger Matcher

This block decides when a logic capture should start. It looks at a set of sampled input channels every time a sample strobe arrives and raises a one-cycle hit pulse once a programmed condition holds. The condition is the logical AND of one term per chosen channel. Each term is a level test (high or low) or an edge test (rising or falling). At most one edge term is allowed.

Software writes the configuration as four words in a fixed order. The words are the channel enable mask, the participation mask, the level-select mask and the polarity mask. A write counter steps through the four words and wraps back to the first. Only the low `NCH` bits of each word are used. Capture control raises `arm` to start a search. While `arm` stays high the block gives at most one hit. Dropping `arm` and raising it again starts a new search.

If no channel takes part, there is nothing to wait for. The first strobe after arming produces the hit at once.

Top module: `trgm_top`

## Requirements
- R1: After reset `trig_hit` is low and all four configuration masks are zero. With that configuration, arming and giving one strobe produces a hit.
- R2: Writes with `cfg_we` fill the masks in a fixed order: enable, participation, level-select, polarity. The fifth write goes back to the enable mask. Bits at position `NCH` and above are ignored.
- R3: A channel whose level-select bit is 1 is a level term. It matches a high sample when its polarity bit is 1 and a low sample when its polarity bit is 0.
- R4: A channel whose level-select bit is 0 is an edge term. It compares the current strobe's sample with the previous strobe's sample. Polarity 0 selects a rising edge (0 then 1). Polarity 1 selects a falling edge (1 then 0).
- R5: A hit needs every active term to match on the same strobe.
- R6: A channel is active only if both its enable bit and its participation bit are 1. Inactive channels never change the result.
- R7: If more than one active channel is an edge term, the configuration is invalid and no hit is produced.
- R8: If no channel is active, the first strobe while armed produces a hit.
- R9: The hit is high for exactly one cycle. Only one hit is given per arming; a new hit needs `arm` to go low and then high again.
- R10: No hit is produced while `arm` is low, or in a cycle with no strobe.
- R11: The stored previous sample is cleared to zero when `arm` rises. A channel that is already high at the first strobe therefore counts as a rising edge.
- R12: `trig_hit` goes high in the cycle right after the clock edge that samples the matching strobe, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for one configuration word |
| cfg_word | input | 32 | Configuration word, taken in sequence |
| arm | input | 1 | Search enable; a rising edge starts a new search |
| smp_stb | input | 1 | A new sample is present on `smp_data` |
| smp_data | input | NCH (16) | Sampled channel values |
| trig_hit | output | 1 | One-cycle trigger hit pulse |

## Verification
A strobe is evaluated at the clock edge that samples it. Its result appears on `trig_hit` exactly one register later. The bench drives each strobe on a falling edge and checks that `trig_hit` is still low before the next rising edge. It then reads the result at the following falling edge, which lies within the single cycle in which the hit is valid. One cycle after that the bench confirms the pulse has gone low again. A configuration write takes effect at the rising edge that follows it, and arming takes effect at the same edge as the first strobe of a search, so every scenario writes its masks and raises `arm` before its first strobe.

// File: rtl/trgm_pkg.sv
package trgm_pkg;

  localparam int unsigned CFG_WORDS = 4;

  typedef enum logic [1:0] {
    SLOT_ENABLE = 2'd0,
    SLOT_PART   = 2'd1,
    SLOT_LEVEL  = 2'd2,
    SLOT_POLAR  = 2'd3
  } cfg_slot_e;

  // One channel's term: level (sel=1) compares with polarity,
  // edge (sel=0) looks for a 0->1 (pol=0) or 1->0 (pol=1) change.
  function automatic logic chan_term(input logic sel_level, input logic pol,
                                     input logic cur, input logic prv);
    logic res;
    if (sel_level) res = (cur == pol);
    else if (pol)  res = prv & ~cur;
    else           res = ~prv & cur;
    return res;
  endfunction

endpackage

// File: rtl/trgm_cfg_loader.sv
module trgm_cfg_loader
  import trgm_pkg::*;
#(
  parameter int unsigned NCH    = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [WORD_W-1:0] word,
  output logic [NCH-1:0]    en_mask,
  output logic [NCH-1:0]    part_mask,
  output logic [NCH-1:0]    lvl_mask,
  output logic [NCH-1:0]    pol_mask
);
  localparam int unsigned IDX_W = $clog2(CFG_WORDS);

  logic [IDX_W-1:0] slot_q;
  logic [NCH-1:0]   word_lo;

  assign word_lo = word[NCH-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q    <= '0;
      en_mask   <= '0;
      part_mask <= '0;
      lvl_mask  <= '0;
      pol_mask  <= '0;
    end else if (we) begin
      slot_q <= (slot_q == IDX_W'(CFG_WORDS - 1)) ? '0 : slot_q + 1'b1;
      case (cfg_slot_e'(slot_q))
        SLOT_ENABLE: en_mask   <= word_lo;
        SLOT_PART:   part_mask <= word_lo;
        SLOT_LEVEL:  lvl_mask  <= word_lo;
        default:     pol_mask  <= word_lo;
      endcase
    end
  end
endmodule

// File: rtl/trgm_term_eval.sv
module trgm_term_eval
  import trgm_pkg::*;
#(
  parameter int unsigned NCH = 16
) (
  input  logic [NCH-1:0] en_mask,
  input  logic [NCH-1:0] part_mask,
  input  logic [NCH-1:0] lvl_mask,
  input  logic [NCH-1:0] pol_mask,
  input  logic [NCH-1:0] cur,
  input  logic [NCH-1:0] prv,
  output logic           cond_met,
  output logic           cfg_bad
);
  localparam int unsigned CNT_W = $clog2(NCH + 1);

  logic [NCH-1:0] active;
  logic [NCH-1:0] term_ok;
  logic [NCH-1:0] edge_act;
  logic [CNT_W-1:0] edge_cnt;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    assign active[g]   = en_mask[g] & part_mask[g];
    assign edge_act[g] = active[g] & ~lvl_mask[g];
    assign term_ok[g]  = ~active[g] |
                         chan_term(lvl_mask[g], pol_mask[g], cur[g], prv[g]);
  end

  always_comb begin
    edge_cnt = '0;
    for (int i = 0; i < NCH; i++) edge_cnt = edge_cnt + CNT_W'(edge_act[i]);
  end

  assign cfg_bad  = (edge_cnt > CNT_W'(1));
  assign cond_met = (&term_ok) & ~cfg_bad;
endmodule

// File: rtl/trgm_seq.sv
module trgm_seq #(
  parameter int unsigned NCH = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           arm,
  input  logic           smp_stb,
  input  logic [NCH-1:0] smp_data,
  input  logic           cond_met,
  output logic [NCH-1:0] prv_eff,
  output logic           arm_rise,
  output logic           done_q,
  output logic           hit_now,
  output logic           hit_q
);
  logic           arm_q;
  logic [NCH-1:0] prv_q;

  assign arm_rise = arm & ~arm_q;
  assign prv_eff  = arm_rise ? '0 : prv_q;
  assign hit_now  = arm & smp_stb & ~done_q & cond_met;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      prv_q  <= '0;
      done_q <= 1'b0;
      hit_q  <= 1'b0;
    end else begin
      arm_q  <= arm;
      hit_q  <= hit_now;
      done_q <= arm & (done_q | hit_now);
      if (arm & smp_stb) prv_q <= smp_data;
      else if (arm_rise) prv_q <= '0;
    end
  end
endmodule

// File: rtl/trgm_top.sv
module trgm_top #(
  parameter int unsigned NCH    = 16,
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic              arm,
  input  logic              smp_stb,
  input  logic [NCH-1:0]    smp_data,
  output logic              trig_hit
);
  logic [NCH-1:0] en_mask, part_mask, lvl_mask, pol_mask;
  logic [NCH-1:0] prv_eff;
  logic           cond_met, cfg_bad, arm_rise, done_q, hit_now, hit_q;

  trgm_cfg_loader #(.NCH(NCH), .WORD_W(WORD_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .word(cfg_word),
    .en_mask(en_mask), .part_mask(part_mask),
    .lvl_mask(lvl_mask), .pol_mask(pol_mask)
  );

  trgm_term_eval #(.NCH(NCH)) u_eval (
    .en_mask(en_mask), .part_mask(part_mask),
    .lvl_mask(lvl_mask), .pol_mask(pol_mask),
    .cur(smp_data), .prv(prv_eff),
    .cond_met(cond_met), .cfg_bad(cfg_bad)
  );

  trgm_seq #(.NCH(NCH)) u_seq (
    .clk(clk), .rst_n(rst_n), .arm(arm), .smp_stb(smp_stb),
    .smp_data(smp_data), .cond_met(cond_met),
    .prv_eff(prv_eff), .arm_rise(arm_rise), .done_q(done_q),
    .hit_now(hit_now), .hit_q(hit_q)
  );

  assign trig_hit = hit_q;
endmodule

// File: rtl/trgm_chk.sv
module trgm_chk #(
  parameter int unsigned NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           arm,
  input logic           smp_stb,
  input logic           trig_hit,
  input logic           done_q,
  input logic [NCH-1:0] en_mask,
  input logic [NCH-1:0] part_mask,
  input logic [NCH-1:0] lvl_mask
);
  // R9: pulse lasts one cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |=> !trig_hit);

  // R10 / R12: a hit follows an armed strobe one cycle earlier
  a_r12_hit_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> ($past(arm) && $past(smp_stb)));

  // R10: nothing while disarmed
  a_r10_no_hit_disarmed: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> !trig_hit);

  // R7: more than one active edge term blocks any hit
  a_r7_multi_edge_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(en_mask & part_mask & ~lvl_mask) > 1) |=> !trig_hit);

  // R8: no active channel, armed strobe, not yet hit -> hit next cycle
  a_r8_no_part_hits: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && smp_stb && !done_q && ((en_mask & part_mask) == '0)) |=> trig_hit);
endmodule

bind trgm_top trgm_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .smp_stb(smp_stb),
  .trig_hit(trig_hit), .done_q(done_q), .en_mask(en_mask),
  .part_mask(part_mask), .lvl_mask(lvl_mask)
);

// File: tb/trgm_top_tb_top.sv
module trgm_top_tb_top;
  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0;
  logic [31:0]    cfg_word = '0;
  logic           arm = 1'b0;
  logic           smp_stb = 1'b0;
  logic [NCH-1:0] smp_data = '0;
  logic           trig_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trgm_top #(.NCH(NCH), .WORD_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_word(cfg_word),
    .arm(arm), .smp_stb(smp_stb), .smp_data(smp_data), .trig_hit(trig_hit)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [31:0] en, input logic [31:0] part,
                           input logic [31:0] lvl, input logic [31:0] pol);
    logic [31:0] w [4];
    w[0] = en; w[1] = part; w[2] = lvl; w[3] = pol;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); cfg_we = 1'b1; cfg_word = w[i];
    end
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rearm();
    @(negedge clk); arm = 1'b0;
    @(negedge clk); arm = 1'b1;
  endtask

  // Drive one strobe; hit must be low before the edge and equal exp after.
  task automatic strobe(input string req, input logic [NCH-1:0] d,
                        input logic exp);
    @(negedge clk); smp_stb = 1'b1; smp_data = d;
    check("R12", trig_hit, 1'b0);
    @(negedge clk); smp_stb = 1'b0;
    check(req, trig_hit, exp);
  endtask

  task automatic t_reset();
    check("R1", trig_hit, 1'b0);
    rearm();
    strobe("R1", 16'h0000, 1'b1);
    @(negedge clk); check("R9", trig_hit, 1'b0);
    strobe("R9", 16'h0000, 1'b0);
  endtask

  task automatic t_level();
    write_cfg(32'hFFFF, 32'h0005, 32'h0005, 32'h0001);
    rearm();
    strobe("R3", 16'h0004, 1'b0);
    strobe("R3", 16'h0001, 1'b1);
    rearm();
    strobe("R5", 16'h0005, 1'b0);
  endtask

  task automatic t_edges();
    write_cfg(32'hFFFF, 32'h0002, 32'h0000, 32'h0000);
    rearm();
    strobe("R4", 16'h0000, 1'b0);
    strobe("R4", 16'h0002, 1'b1);
    write_cfg(32'hFFFF, 32'h0002, 32'h0000, 32'h0002);
    rearm();
    strobe("R4", 16'h0002, 1'b0);
    strobe("R4", 16'h0000, 1'b1);
  endtask

  task automatic t_mixed();
    write_cfg(32'hFFFF, 32'h0009, 32'h0001, 32'h0001);
    rearm();
    strobe("R5", 16'h0001, 1'b0);
    strobe("R5", 16'h0008, 1'b0);
    strobe("R5", 16'h0000, 1'b0);
    strobe("R5", 16'h0009, 1'b1);
  endtask

  task automatic t_ignore();
    write_cfg(32'hFFFF, 32'h0001, 32'h0001, 32'h0001);
    rearm();
    strobe("R6", 16'hFFFE, 1'b0);
    strobe("R6", 16'h0001, 1'b1);
    write_cfg(32'hFFFE, 32'h0003, 32'h0003, 32'h0003);
    rearm();
    strobe("R6", 16'h0002, 1'b1);
  endtask

  task automatic t_two_edges();
    write_cfg(32'hFFFF, 32'h0003, 32'h0000, 32'h0000);
    rearm();
    strobe("R7", 16'h0000, 1'b0);
    strobe("R7", 16'h0003, 1'b0);
    strobe("R7", 16'h0000, 1'b0);
    strobe("R7", 16'h0001, 1'b0);
  endtask

  task automatic t_no_arm();
    write_cfg(32'hFFFF, 32'h0001, 32'h0001, 32'h0001);
    @(negedge clk); arm = 1'b0;
    strobe("R10", 16'h0001, 1'b0);
    @(negedge clk); arm = 1'b1; smp_data = 16'h0001;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); check("R10", trig_hit, 1'b0);
    end
    strobe("R10", 16'h0001, 1'b1);
  endtask

  task automatic t_prev_clear();
    write_cfg(32'hFFFF, 32'h0002, 32'h0000, 32'h0000);
    rearm();
    strobe("R11", 16'h0002, 1'b1);
    rearm();
    strobe("R11", 16'h0002, 1'b1);
  endtask

  task automatic t_upper_bits();
    write_cfg(32'hFFFF, 32'h0001_0000, 32'h0000, 32'h0000);
    rearm();
    strobe("R2", 16'h0000, 1'b1);
    write_cfg(32'h0001_0000, 32'h0001, 32'h0001, 32'h0001);
    rearm();
    strobe("R2", 16'h0000, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_level();
    t_edges();
    t_mixed();
    t_ignore();
    t_two_edges();
    t_no_arm();
    t_prev_clear();
    t_upper_bits();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule